// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block produces the fetch-address stream for a small in-order processor whose control transfers take effect one instruction late. It holds two registers: the address of the instruction now issuing (PC) and the address of the one after it (nPC). Each cycle the decode stage presents a descriptor for the issuing instruction. The descriptor carries a transfer kind, the evaluated condition, an annul flag and a target address. From it the sequencer chooses the next PC and nPC.

In the normal case the instruction right after a transfer (the delay instruction) still runs before the instruction at the target. A trap-style transfer goes straight to its target and never runs the following instruction. The annul flag can cancel the delay instruction. A cancelled instruction is still fetched, but it issues with a squash flag raised so that it writes no state. Its own descriptor is disregarded.

Top module: `delay_slot_pc_seq`

## Requirements
- R1: While rst_n is low at a rising edge, PC loads RESET_VEC and nPC loads RESET_VEC+4, and the squash flag clears. After reset, issue_pc reads RESET_VEC and issue_squash reads 0.
- R2: An instruction with xfer_kind 2'b00 (sequential) moves PC to nPC and nPC to nPC+4.
- R3: xfer_kind 2'b01 (unconditional jump) with annul_bit 0 issues the delay instruction next and then the target. For op A, jump to T, op B, the issue order is A, jump, B, T.
- R4: xfer_kind 2'b10 (conditional branch) redirects to xfer_target after its delay instruction only when cond_met is 1. Otherwise execution continues in sequence.
- R5: xfer_kind 2'b11 (trap) makes the next issued address xfer_target, sets nPC to xfer_target+4, and never issues the following instruction.
- R6: A conditional branch with annul_bit 1 squashes its delay instruction when it is not taken, and lets it execute (issue_squash 0) when it is taken.
- R7: An unconditional jump with annul_bit 1 always squashes its delay instruction. The target is still reached after that instruction.
- R8: While issue_squash is 1, the descriptor inputs have no effect. Addresses advance as for a sequential instruction, and issue_squash is 0 on the following cycle.
- R9: A transfer that sits in a delay slot uses the already-loaded nPC as its fall-through. After two back-to-back jumps, the first target issues next, followed by the second target.
- R10: fetch_addr always equals the issue_pc that will be presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_kind | input | 2 | Transfer kind of the issuing instruction: 00 sequential, 01 jump, 10 branch, 11 trap |
| cond_met | input | 1 | Evaluated branch condition |
| annul_bit | input | 1 | Annul flag of the transfer |
| xfer_target | input | AW | Target address, used for jumps, branches and traps |
| issue_pc | output | AW | Address of the instruction now issuing |
| fetch_addr | output | AW | Address to fetch next |
| issue_squash | output | 1 | The issuing instruction is cancelled and must write no state |

## Verification
The hardest case to reach from the ports is a squashed instruction that is itself a transfer. Its descriptor must be ignored, and it only exists in the cycle right after an annulled jump or an untaken annulled branch. The vector table drives a jump descriptor into exactly that cycle and checks that the addresses continue in sequence. The table also places a jump in the delay slot of another jump to exercise the nPC chain. Directed tests then apply reset while a squash is pending.

// File: rtl/pcseq_pkg.sv
// Shared types for the delayed-branch sequencer.
// Assumes the decode stage encodes the transfer kind in two bits.
package pcseq_pkg;
    typedef enum logic [1:0] {
        XK_SEQ    = 2'b00,
        XK_JUMP   = 2'b01,
        XK_BRANCH = 2'b10,
        XK_TRAP   = 2'b11
    } xfer_kind_e;
endpackage

// File: rtl/pcseq_next.sv
// Next-state logic: picks the next PC, nPC and squash flag from the
// current state and the descriptor of the instruction now issuing.
// Assumes a squashed instruction's descriptor must be disregarded.
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  xfer_kind_e        kind,
    input  logic              cond_met,
    input  logic              annul_bit,
    input  logic [AW-1:0]     target,
    input  logic [AW-1:0]     npc_q,
    input  logic              squash_q,
    output logic [AW-1:0]     pc_nxt,
    output logic [AW-1:0]     npc_nxt,
    output logic              squash_nxt
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic redirect;
    logic trap_go;

    // Decode the transfer decision for a live (non-squashed) instruction.
    always_comb begin
        redirect   = 1'b0;
        trap_go    = 1'b0;
        squash_nxt = 1'b0;
        if (!squash_q) begin
            unique case (kind)
                XK_JUMP: begin
                    redirect   = 1'b1;
                    squash_nxt = annul_bit;
                end
                XK_BRANCH: begin
                    if (cond_met) redirect   = 1'b1;
                    else          squash_nxt = annul_bit;
                end
                XK_TRAP:  trap_go = 1'b1;
                default:  ;
            endcase
        end
    end

    // Form the address pair: trap skips the delay slot, others shift nPC in.
    always_comb begin
        if (trap_go) begin
            pc_nxt  = target;
            npc_nxt = target + STEP_V;
        end else begin
            pc_nxt  = npc_q;
            npc_nxt = redirect ? target : npc_q + STEP_V;
        end
    end
endmodule

// File: rtl/pcseq_state.sv
// PC / nPC / squash registers with synchronous active-low reset.
// Assumes one instruction issues every cycle.
module pcseq_state #(
    parameter int              AW        = 32,
    parameter int              STEP      = 4,
    parameter logic [AW-1:0]   RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     pc_nxt,
    input  logic [AW-1:0]     npc_nxt,
    input  logic              squash_nxt,
    output logic [AW-1:0]     pc_q,
    output logic [AW-1:0]     npc_q,
    output logic              squash_q
);
    localparam logic [AW-1:0] RESET_NPC = RESET_VEC + AW'(STEP);

    // Register the address pair and the pending squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_VEC;
            npc_q    <= RESET_NPC;
            squash_q <= 1'b0;
        end else begin
            pc_q     <= pc_nxt;
            npc_q    <= npc_nxt;
            squash_q <= squash_nxt;
        end
    end

    // R1
    reset_vec_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == RESET_VEC && npc_q == RESET_NPC && !squash_q));

    // R8
    squash_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_q |=> !squash_q);
endmodule

// File: rtl/delay_slot_pc_seq.sv
// Top of the delayed-branch program counter sequencer. Takes the
// descriptor of the issuing instruction each cycle and produces the
// next fetch address plus a squash flag for the issuing instruction.
// Assumes the descriptor inputs are valid every cycle.
module delay_slot_pc_seq
    import pcseq_pkg::*;
#(
    parameter int              AW        = 32,
    parameter int              STEP      = 4,
    parameter logic [AW-1:0]   RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        xfer_kind,
    input  logic              cond_met,
    input  logic              annul_bit,
    input  logic [AW-1:0]     xfer_target,
    output logic [AW-1:0]     issue_pc,
    output logic [AW-1:0]     fetch_addr,
    output logic              issue_squash
);
    logic [AW-1:0] pc_q, npc_q, pc_nxt, npc_nxt;
    logic          squash_q, squash_nxt;
    xfer_kind_e    kind;

    // Map the raw kind bits onto the shared enum.
    always_comb kind = xfer_kind_e'(xfer_kind);

    pcseq_next #(.AW(AW), .STEP(STEP)) u_next (
        .kind       (kind),
        .cond_met   (cond_met),
        .annul_bit  (annul_bit),
        .target     (xfer_target),
        .npc_q      (npc_q),
        .squash_q   (squash_q),
        .pc_nxt     (pc_nxt),
        .npc_nxt    (npc_nxt),
        .squash_nxt (squash_nxt)
    );

    pcseq_state #(.AW(AW), .STEP(STEP), .RESET_VEC(RESET_VEC)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_nxt     (pc_nxt),
        .npc_nxt    (npc_nxt),
        .squash_nxt (squash_nxt),
        .pc_q       (pc_q),
        .npc_q      (npc_q),
        .squash_q   (squash_q)
    );

    // Drive the outputs from the state and the chosen next address.
    always_comb begin
        issue_pc     = pc_q;
        issue_squash = squash_q;
        fetch_addr   = pc_nxt;
    end

    // R5
    trap_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_kind == 2'b11 && !issue_squash) |=>
            (issue_pc == $past(xfer_target) && !issue_squash));

    // R2
    delay_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_kind != 2'b11 || issue_squash) |=> (issue_pc == $past(npc_q)));

    // R7
    jump_annul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_kind == 2'b01 && annul_bit && !issue_squash) |=> issue_squash);

    // R6
    taken_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_kind == 2'b10 && cond_met && !issue_squash) |=> !issue_squash);

    // R10
    fetch_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (issue_pc == $past(fetch_addr)));
endmodule

// File: tb/delay_slot_pc_seq_test.sv
`timescale 1ns/1ps
module delay_slot_pc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  xfer_kind = 2'b00;
    logic        cond_met = 1'b0;
    logic        annul_bit = 1'b0;
    logic [31:0] xfer_target = '0;
    logic [31:0] issue_pc, fetch_addr;
    logic        issue_squash;

    int n_run = 0;
    int n_fail = 0;

    delay_slot_pc_seq #(.AW(32), .STEP(4), .RESET_VEC(32'h100)) uut (
        .clk(clk), .rst_n(rst_n), .xfer_kind(xfer_kind), .cond_met(cond_met),
        .annul_bit(annul_bit), .xfer_target(xfer_target),
        .issue_pc(issue_pc), .fetch_addr(fetch_addr), .issue_squash(issue_squash)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [1:0]  k;
        logic        c;
        logic        a;
        logic [31:0] tgt;
        logic [31:0] pc;
        logic        sq;
        logic [31:0] fa;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'b00,1'b0,1'b0,32'h000,32'h100,1'b0,32'h104}, // R2 sequential
        '{2'b01,1'b0,1'b0,32'h200,32'h104,1'b0,32'h108}, // R3 jump
        '{2'b00,1'b0,1'b0,32'h000,32'h108,1'b0,32'h200}, // R3 delay op
        '{2'b10,1'b1,1'b1,32'h300,32'h200,1'b0,32'h204}, // R4/R6 taken annul
        '{2'b00,1'b0,1'b0,32'h000,32'h204,1'b0,32'h300}, // R6 slot executes
        '{2'b10,1'b0,1'b1,32'h400,32'h300,1'b0,32'h304}, // R6 untaken annul
        '{2'b01,1'b0,1'b0,32'h500,32'h304,1'b1,32'h308}, // R8 squashed jump ignored
        '{2'b01,1'b0,1'b1,32'h600,32'h308,1'b0,32'h30C}, // R7 jump annul
        '{2'b00,1'b0,1'b0,32'h000,32'h30C,1'b1,32'h600}, // R7 slot squashed
        '{2'b11,1'b0,1'b0,32'h700,32'h600,1'b0,32'h700}, // R5 trap
        '{2'b10,1'b0,1'b0,32'h800,32'h700,1'b0,32'h704}, // R4 untaken
        '{2'b00,1'b0,1'b0,32'h000,32'h704,1'b0,32'h708}, // R4 fall-through
        '{2'b01,1'b0,1'b0,32'h900,32'h708,1'b0,32'h70C}, // R9 first jump
        '{2'b01,1'b0,1'b0,32'hA00,32'h70C,1'b0,32'h900}, // R9 jump in slot
        '{2'b00,1'b0,1'b0,32'h000,32'h900,1'b0,32'hA00}, // R9 first target
        '{2'b00,1'b0,1'b0,32'h000,32'hA00,1'b0,32'hA04}  // R9 second target
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] k, input logic c, input logic a, input logic [31:0] t);
        xfer_kind = k; cond_met = c; annul_bit = a; xfer_target = t;
    endtask

    initial begin
        #20000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check32("R1 pc", issue_pc, 32'h100);
        check1("R1 squash", issue_squash, 1'b0);

        for (int i = 0; i < NV; i++) begin
            check32($sformatf("R2/R3 step %0d issue_pc", i), issue_pc, VECS[i].pc);
            check1($sformatf("R6/R7/R8 step %0d squash", i), issue_squash, VECS[i].sq);
            drive(VECS[i].k, VECS[i].c, VECS[i].a, VECS[i].tgt);
            #1;
            check32($sformatf("R10 step %0d fetch_addr", i), fetch_addr, VECS[i].fa);
            @(negedge clk);
        end

        // R1: reset while a squash is pending
        drive(2'b01, 1'b0, 1'b1, 32'hB00);
        @(negedge clk);
        check1("R7 squash pending", issue_squash, 1'b1);
        rst_n = 1'b0;
        drive(2'b00, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        check32("R1 pc after mid reset", issue_pc, 32'h100);
        check1("R1 squash cleared", issue_squash, 1'b0);

        // R5: trap issued right after reset, following op never issues
        drive(2'b11, 1'b1, 1'b1, 32'hC00);
        @(negedge clk);
        drive(2'b00, 1'b0, 1'b0, 32'h0);
        check32("R5 trap target", issue_pc, 32'hC00);
        check1("R5 no squash", issue_squash, 1'b0);
        @(negedge clk);
        check32("R5 after trap", issue_pc, 32'hC04);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule